// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces display timing from registers that software loads before starting it. One position counter advances on every pixel clock and runs across the whole frame. A second counter tracks the pixel position inside the current line. Horizontal events are compared against the line position. Vertical events are compared against the frame position, so they are expressed in pixel clocks rather than in lines. Any horizontal skew is already folded into the vertical positions that software writes.

The block drives hsync, vsync, a data-enable flag and the pixel bus. It also asks an upstream source for pixels through a ready flag, and the source answers with a valid flag in the same cycle. An optional active sub-window can sit inside the display window. Pixels that are displayed but lie outside that sub-window get a border colour. A requested pixel that the source does not supply gets an underflow colour and sets a sticky flag. The block can also emit a single-cycle fetch pulse at a programmed frame position. Software can read a frame counter and a line counter, and each of them can be enabled on its own.

Top module: `video_timing_gen`

## Requirements
- R1: After reset, hsync, vsync, de, fetch_pulse, in_ready and pix_data are all 0, and the frame and line counters read 0.
- R2: Register 2 holds the line period in pixels in bits 31:16 and the hsync width in bits 15:0. For the pixel at line position h, hsync is active when h < width. Every output shows the values for a frame position one clock after the cycle that holds that position.
- R3: Register 3 holds the frame period and register 4 the vsync width, both in pixel clocks. vsync is active while the frame position is below register 4. The position wraps to 0 after it reaches the period minus 1.
- R4: de is active when two conditions hold together. The line position must lie within register 5, which holds the last position in bits 31:16 and the first in bits 15:0. The frame position must lie between register 6 (first) and register 7 (last), both ends included.
- R5: Register 1 bit 29 enables a horizontal active window, given by register 8 (last in 31:16, first in 15:0). Register 1 bit 30 enables a vertical active window, given by register 9 (first) and register 10 (last). A displayed pixel outside an enabled window is driven with the border colour in register 11. pix_data is 0 outside the display window.
- R6: in_ready is high exactly for displayed pixels inside all enabled active windows. For such a pixel with in_valid high, in_data appears on pix_data.
- R7: A requested pixel with in_valid low is driven with the colour in register 12, and sets status bit 0 (register 18). The bit stays set until software writes 1 to it. in_valid low on a pixel that is not requested has no effect on the bit.
- R8: Register 13 bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de. The inversion also applies to the idle levels.
- R9: When register 1 bit 31 is set, fetch_pulse is high for exactly one clock per frame, at the frame position held in register 15.
- R10: Register 14 bit 0 enables the frame counter (read at register 16) and bit 1 enables the line counter (read at register 17). The line counter restarts at 0 every frame. A counter that is not enabled reads 0.
- R11: Register 0 bit 0 runs the engine. While it is clear, the counters are held at 0 and the outputs sit at their idle levels. Setting it starts at frame position 0, so vsync is asserted first.
- R12: Registers 0 to 15 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write word index |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read word index |
| rd_data | output | 32 | Register read data, combinational |
| in_valid | input | 1 | Upstream pixel present this cycle |
| in_data | input | PIX_W | Upstream pixel |
| in_ready | output | 1 | Pixel requested this cycle |
| pix_data | output | PIX_W | Output pixel |
| hsync | output | 1 | Line sync after polarity |
| vsync | output | 1 | Frame sync after polarity |
| de | output | 1 | Data enable after polarity |
| fetch_pulse | output | 1 | Programmable fetch-start pulse |

## Verification
The assertions assume that the frame period and the line period are nonzero and unchanged while the engine runs. The bench keeps to this by writing all timing registers only while the engine is stopped. The assertions also assume that the source answers in_ready in the same cycle. The bench does this by driving in_valid and in_data for each position before the edge that samples them. Two geometries are each swept over more than two full frames, and every output is compared on every cycle. One geometry has active windows, counters and normal polarity. The other has a skewed vertical window, all polarities inverted, counters disabled and a late fetch position.

// File: rtl/vtg_pkg.sv
// Package: shared widths, register word indices, config bit positions and
// the decoded timing configuration handed from the register file.
package vtg_pkg;
    localparam int REG_AW  = 5;
    localparam int DATA_W  = 32;
    localparam int HPOS_W  = 16;
    localparam int VPOS_W  = 32;
    localparam int LCNT_W  = 16;
    localparam int NUM_RW  = 16;
    localparam int RW_IW   = $clog2(NUM_RW);

    // Register word indices
    localparam int A_ENABLE   = 0;
    localparam int A_CONFIG   = 1;
    localparam int A_LINE_CTL = 2;
    localparam int A_FRM_LEN  = 3;
    localparam int A_VS_LEN   = 4;
    localparam int A_DISP_H   = 5;
    localparam int A_DISP_V0  = 6;
    localparam int A_DISP_V1  = 7;
    localparam int A_ACT_H    = 8;
    localparam int A_ACT_V0   = 9;
    localparam int A_ACT_V1   = 10;
    localparam int A_BORDER   = 11;
    localparam int A_UFL_CLR  = 12;
    localparam int A_POLARITY = 13;
    localparam int A_CNT_EN   = 14;
    localparam int A_FETCH    = 15;
    localparam int A_FRM_CNT  = 16;
    localparam int A_LINE_CNT = 17;
    localparam int A_STATUS   = 18;

    // Config register bit positions
    localparam int CFG_HACT_BIT  = 29;
    localparam int CFG_VACT_BIT  = 30;
    localparam int CFG_FETCH_BIT = 31;

    typedef struct packed {
        logic              en;
        logic              hact_en;
        logic              vact_en;
        logic              fetch_en;
        logic [2:0]        pol;
        logic [1:0]        cnt_en;
        logic [HPOS_W-1:0] h_period;
        logic [HPOS_W-1:0] hsync_w;
        logic [HPOS_W-1:0] dh_first;
        logic [HPOS_W-1:0] dh_last;
        logic [HPOS_W-1:0] ah_first;
        logic [HPOS_W-1:0] ah_last;
        logic [VPOS_W-1:0] frame_len;
        logic [VPOS_W-1:0] vsync_len;
        logic [VPOS_W-1:0] dv_first;
        logic [VPOS_W-1:0] dv_last;
        logic [VPOS_W-1:0] av_first;
        logic [VPOS_W-1:0] av_last;
        logic [VPOS_W-1:0] fetch_pos;
    } vtg_cfg_t;
endpackage

// File: rtl/vtg_regs.sv
// Register file: sixteen read/write words, the read-only counters and the
// sticky underflow flag. Reads are combinational. It assumes one write per
// cycle. An underflow event in the same cycle as a clearing write wins.
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [VPOS_W-1:0] frame_cnt,
    input  logic [LCNT_W-1:0] line_cnt,
    input  logic              uflow_evt,
    output vtg_cfg_t          cfg,
    output logic [PIX_W-1:0]  border_colour,
    output logic [PIX_W-1:0]  uflow_colour,
    output logic              uflow_flag
);
    logic [DATA_W-1:0] rw_q [NUM_RW];

    // Store software writes into the read/write words
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_RW; i++) begin
            if (!rst_n)
                rw_q[i] <= '0;
            else if (wr_en && wr_addr == REG_AW'(i))
                rw_q[i] <= wr_data;
        end
    end

    // Sticky underflow flag, cleared by writing 1 to status bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            uflow_flag <= 1'b0;
        else if (uflow_evt)
            uflow_flag <= 1'b1;
        else if (wr_en && wr_addr == REG_AW'(A_STATUS) && wr_data[0])
            uflow_flag <= 1'b0;
    end

    // Unpack the words into the timing configuration
    always_comb begin
        cfg.en        = rw_q[A_ENABLE][0];
        cfg.hact_en   = rw_q[A_CONFIG][CFG_HACT_BIT];
        cfg.vact_en   = rw_q[A_CONFIG][CFG_VACT_BIT];
        cfg.fetch_en  = rw_q[A_CONFIG][CFG_FETCH_BIT];
        cfg.pol       = rw_q[A_POLARITY][2:0];
        cfg.cnt_en    = rw_q[A_CNT_EN][1:0];
        cfg.h_period  = rw_q[A_LINE_CTL][31:16];
        cfg.hsync_w   = rw_q[A_LINE_CTL][15:0];
        cfg.dh_last   = rw_q[A_DISP_H][31:16];
        cfg.dh_first  = rw_q[A_DISP_H][15:0];
        cfg.ah_last   = rw_q[A_ACT_H][31:16];
        cfg.ah_first  = rw_q[A_ACT_H][15:0];
        cfg.frame_len = rw_q[A_FRM_LEN];
        cfg.vsync_len = rw_q[A_VS_LEN];
        cfg.dv_first  = rw_q[A_DISP_V0];
        cfg.dv_last   = rw_q[A_DISP_V1];
        cfg.av_first  = rw_q[A_ACT_V0];
        cfg.av_last   = rw_q[A_ACT_V1];
        cfg.fetch_pos = rw_q[A_FETCH];
        border_colour = rw_q[A_BORDER][PIX_W-1:0];
        uflow_colour  = rw_q[A_UFL_CLR][PIX_W-1:0];
    end

    // Read multiplexer over read/write words and read-only state
    always_comb begin
        if (rd_addr < REG_AW'(NUM_RW))
            rd_data = rw_q[rd_addr[RW_IW-1:0]];
        else if (rd_addr == REG_AW'(A_FRM_CNT))
            rd_data = frame_cnt;
        else if (rd_addr == REG_AW'(A_LINE_CNT))
            rd_data = DATA_W'(line_cnt);
        else if (rd_addr == REG_AW'(A_STATUS))
            rd_data = DATA_W'(uflow_flag);
        else
            rd_data = '0;
    end
endmodule

// File: rtl/vtg_counter.sv
// Position counters: frame position in pixel clocks, position in the line,
// and the enabled line and frame counters. All are held at zero while the
// engine is stopped. It assumes nonzero periods that do not change while
// it runs.
module vtg_counter
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [HPOS_W-1:0] h_period,
    input  logic [VPOS_W-1:0] frame_len,
    input  logic [1:0]        cnt_en,
    output logic [VPOS_W-1:0] pos,
    output logic [HPOS_W-1:0] hpos,
    output logic [LCNT_W-1:0] line_cnt,
    output logic [VPOS_W-1:0] frame_cnt
);
    logic frame_end;
    logic line_end;

    assign frame_end = (pos >= frame_len - VPOS_W'(1));
    assign line_end  = (hpos >= h_period - HPOS_W'(1));

    // Advance positions, wrap at line and frame ends, clear when stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pos       <= '0;
            hpos      <= '0;
            line_cnt  <= '0;
            frame_cnt <= '0;
        end else if (frame_end) begin
            pos      <= '0;
            hpos     <= '0;
            line_cnt <= '0;
            if (cnt_en[0])
                frame_cnt <= frame_cnt + VPOS_W'(1);
        end else begin
            pos  <= pos + VPOS_W'(1);
            hpos <= line_end ? '0 : hpos + HPOS_W'(1);
            if (line_end && cnt_en[1])
                line_cnt <= line_cnt + LCNT_W'(1);
        end
    end
endmodule

// File: rtl/vtg_decode.sv
// Window decode and pixel selection for the current position. It is purely
// combinational. The top module registers its result. It assumes that the
// source answers in_ready within the same cycle.
module vtg_decode
    import vtg_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  vtg_cfg_t          cfg,
    input  logic [VPOS_W-1:0] pos,
    input  logic [HPOS_W-1:0] hpos,
    input  logic [PIX_W-1:0]  border_colour,
    input  logic [PIX_W-1:0]  uflow_colour,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_data,
    output logic              in_ready,
    output logic              uflow_evt,
    output logic              nxt_hs,
    output logic              nxt_vs,
    output logic              nxt_de,
    output logic              nxt_fetch,
    output logic [PIX_W-1:0]  nxt_pix
);
    logic in_disp_h, in_disp_v, in_act_h, in_act_v, disp, act;

    // Window membership for the current position
    always_comb begin
        in_disp_h = (hpos >= cfg.dh_first) && (hpos <= cfg.dh_last);
        in_disp_v = (pos >= cfg.dv_first) && (pos <= cfg.dv_last);
        in_act_h  = !cfg.hact_en || ((hpos >= cfg.ah_first) && (hpos <= cfg.ah_last));
        in_act_v  = !cfg.vact_en || ((pos >= cfg.av_first) && (pos <= cfg.av_last));
        disp      = cfg.en && in_disp_h && in_disp_v;
        act       = disp && in_act_h && in_act_v;
    end

    // Sync, request and pixel selection
    always_comb begin
        in_ready  = act;
        uflow_evt = act && !in_valid;
        nxt_hs    = cfg.en && (hpos < cfg.hsync_w);
        nxt_vs    = cfg.en && (pos < cfg.vsync_len);
        nxt_de    = disp;
        nxt_fetch = cfg.en && cfg.fetch_en && (pos == cfg.fetch_pos);
        if (!disp)
            nxt_pix = '0;
        else if (!act)
            nxt_pix = border_colour;
        else if (in_valid)
            nxt_pix = in_data;
        else
            nxt_pix = uflow_colour;
    end
endmodule

// File: rtl/video_timing_gen.sv
// Top: register file, position counters, window decode and one output
// register stage. Outputs show each frame position one clock after the
// position is held. Polarity is applied at the output register, so the
// idle levels follow it.
module video_timing_gen
    import vtg_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_data,
    output logic              in_ready,
    output logic [PIX_W-1:0]  pix_data,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              fetch_pulse
);
    vtg_cfg_t          cfg;
    logic              eng_en;
    logic [PIX_W-1:0]  border_colour, uflow_colour;
    logic              uflow_evt, uflow_flag;
    logic [VPOS_W-1:0] pos, frame_cnt;
    logic [HPOS_W-1:0] hpos;
    logic [LCNT_W-1:0] line_cnt;
    logic              nxt_hs, nxt_vs, nxt_de, nxt_fetch;
    logic [PIX_W-1:0]  nxt_pix;

    assign eng_en = cfg.en;

    vtg_regs #(.PIX_W(PIX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_cnt(frame_cnt), .line_cnt(line_cnt), .uflow_evt(uflow_evt),
        .cfg(cfg), .border_colour(border_colour), .uflow_colour(uflow_colour),
        .uflow_flag(uflow_flag)
    );

    vtg_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .en(eng_en), .h_period(cfg.h_period),
        .frame_len(cfg.frame_len), .cnt_en(cfg.cnt_en), .pos(pos),
        .hpos(hpos), .line_cnt(line_cnt), .frame_cnt(frame_cnt)
    );

    vtg_decode #(.PIX_W(PIX_W)) u_dec (
        .cfg(cfg), .pos(pos), .hpos(hpos), .border_colour(border_colour),
        .uflow_colour(uflow_colour), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .uflow_evt(uflow_evt), .nxt_hs(nxt_hs),
        .nxt_vs(nxt_vs), .nxt_de(nxt_de), .nxt_fetch(nxt_fetch),
        .nxt_pix(nxt_pix)
    );

    // Output register with polarity applied
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync       <= 1'b0;
            vsync       <= 1'b0;
            de          <= 1'b0;
            fetch_pulse <= 1'b0;
            pix_data    <= '0;
        end else begin
            hsync       <= nxt_hs ^ cfg.pol[0];
            vsync       <= nxt_vs ^ cfg.pol[1];
            de          <= nxt_de ^ cfg.pol[2];
            fetch_pulse <= nxt_fetch;
            pix_data    <= nxt_pix;
        end
    end
endmodule

// File: rtl/vtg_checker.sv
// Checker: temporal properties of the timing generator, bound to the top.
// It assumes nonzero periods that stay constant while the engine runs.
module vtg_checker
    import vtg_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [VPOS_W-1:0] pos,
    input logic [VPOS_W-1:0] frame_len,
    input logic [VPOS_W-1:0] frame_cnt,
    input logic              uflow_flag,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic              wr_bit0,
    input logic              in_ready,
    input logic              in_valid,
    input logic [PIX_W-1:0]  in_data,
    input logic [PIX_W-1:0]  pix_data,
    input logic              fetch_pulse
);
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pix_data == '0 && !fetch_pulse)); // R11

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pos == frame_len - VPOS_W'(1)) |=> (pos == '0)); // R3

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (pix_data == $past(in_data))); // R6

    AST_UFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> uflow_flag); // R7

    AST_UFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow_flag && !(wr_en && wr_addr == REG_AW'(A_STATUS) && wr_bit0))
        |=> uflow_flag); // R7

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (frame_cnt == $past(frame_cnt) ||
                frame_cnt == $past(frame_cnt) + VPOS_W'(1))); // R10
endmodule

bind video_timing_gen vtg_checker #(.PIX_W(PIX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(eng_en), .pos(pos),
    .frame_len(cfg.frame_len), .frame_cnt(frame_cnt),
    .uflow_flag(uflow_flag), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bit0(wr_data[0]), .in_ready(in_ready), .in_valid(in_valid),
    .in_data(in_data), .pix_data(pix_data), .fetch_pulse(fetch_pulse)
);

// File: tb/video_timing_gen_test.sv
`timescale 1ns/1ps
// Bench: full-frame sweeps over two small geometries. Each expected output
// is computed from the programmed timing numbers with line/pixel arithmetic.
module video_timing_gen_test;
    localparam int PIX_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [4:0]       wr_addr = '0;
    logic [31:0]      wr_data = '0;
    logic [4:0]       rd_addr = '0;
    logic [31:0]      rd_data;
    logic             in_valid = 1'b0;
    logic [PIX_W-1:0] in_data = '0;
    logic             in_ready;
    logic [PIX_W-1:0] pix_data;
    logic             hsync, vsync, de, fetch_pulse;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // Geometry of the current configuration
    int hp, hsw, hbp, hfp, vsw, vbp, nl, vfp, skew, fp;
    int use_ha, use_va, ahs, ahe, avs, ave;
    int fetch_on, fetch_at, cnt_on, mark_b, mark_abs;
    logic [2:0] pol;
    logic [PIX_W-1:0] border_c = 24'hB0B0B0;
    logic [PIX_W-1:0] uflow_c  = 24'h0F0F0F;
    bit sticky_exp;
    string tg;

    video_timing_gen #(.PIX_W(PIX_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .pix_data(pix_data), .hsync(hsync), .vsync(vsync), .de(de),
        .fetch_pulse(fetch_pulse)
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        rd_addr = 5'(a);
        #0.2;
        d = rd_data;
    endtask

    function automatic bit f_disp(int p);
        int h = p % hp;
        int v0 = (vsw + vbp) * hp + skew;
        int v1 = (nl - vfp) * hp + skew - 1;
        return (h >= hsw + hbp) && (h <= hp - hfp - 1) && (p >= v0) && (p <= v1);
    endfunction

    function automatic bit f_act(int p);
        int h = p % hp;
        return f_disp(p) && (use_ha == 0 || (h >= ahs && h <= ahe))
                         && (use_va == 0 || (p >= avs && p <= ave));
    endfunction

    function automatic bit f_vld(int k);
        return !((k % fp) == mark_b || k == mark_abs);
    endfunction

    function automatic logic [PIX_W-1:0] f_data(int k);
        return {8'h5A, 16'(k)};
    endfunction

    task automatic drive(input int k);
        in_valid = f_vld(k);
        in_data  = f_data(k);
        #0.2;
        chk({tg, " R6 in_ready"}, 32'(in_ready), 32'(f_act(k % fp)));
    endtask

    // Compare outputs that show position k, then counters and status
    task automatic check_cycle(input int k);
        int p = k % fp;
        logic [PIX_W-1:0] ep;
        logic [31:0] r;
        if (!f_disp(p))     ep = '0;
        else if (!f_act(p)) ep = border_c;
        else if (f_vld(k))  ep = f_data(k);
        else                ep = uflow_c;
        chk({tg, " R2 hsync"}, 32'(hsync), 32'(((p % hp) < hsw) ^ pol[0]));
        chk({tg, " R3 vsync"}, 32'(vsync), 32'((p < vsw * hp) ^ pol[1]));
        chk({tg, " R4 de"}, 32'(de), 32'(f_disp(p) ^ pol[2]));
        chk({tg, " R5 R6 R7 pix_data"}, 32'(pix_data), 32'(ep));
        chk({tg, " R9 fetch_pulse"}, 32'(fetch_pulse), 32'(fetch_on != 0 && p == fetch_at));
        if (f_act(p) && !f_vld(k)) sticky_exp = 1;
        rd(18, r); chk({tg, " R7 status"}, r, 32'(sticky_exp));
        rd(16, r); chk({tg, " R10 frame count"}, r, cnt_on != 0 ? 32'((k + 1) / fp) : 32'd0);
        rd(17, r); chk({tg, " R10 line count"}, r, cnt_on != 0 ? 32'(((k + 1) % fp) / hp) : 32'd0);
    endtask

    task automatic program_cfg();
        fp = nl * hp;
        wr(2, 32'((hp << 16) | hsw));
        wr(3, 32'(fp));
        wr(4, 32'(vsw * hp));
        wr(5, 32'(((hp - hfp - 1) << 16) | (hsw + hbp)));
        wr(6, 32'((vsw + vbp) * hp + skew));
        wr(7, 32'((nl - vfp) * hp + skew - 1));
        wr(8, 32'((ahe << 16) | ahs));
        wr(9, 32'(avs));
        wr(10, 32'(ave));
        wr(11, 32'(border_c));
        wr(12, 32'(uflow_c));
        wr(13, 32'(pol));
        wr(14, cnt_on != 0 ? 32'h3 : 32'h0);
        wr(15, 32'(fetch_at));
        wr(1, {fetch_on != 0, use_va != 0, use_ha != 0, 29'b0});
    endtask

    // Check idle levels for the current polarity
    task automatic check_idle(input string t);
        logic [31:0] r;
        chk({t, " hsync idle"}, 32'(hsync), 32'(pol[0]));
        chk({t, " vsync idle"}, 32'(vsync), 32'(pol[1]));
        chk({t, " de idle"}, 32'(de), 32'(pol[2]));
        chk({t, " pix idle"}, 32'(pix_data), 32'd0);
        chk({t, " fetch idle"}, 32'(fetch_pulse), 32'd0);
        rd(16, r); chk({t, " frame count idle"}, r, 32'd0);
        rd(17, r); chk({t, " line count idle"}, r, 32'd0);
        #0.2;
        chk({t, " ready idle"}, 32'(in_ready), 32'd0);
    endtask

    task automatic run(input int n);
        wr(0, 32'h1);
        check_idle({tg, " R11 pre-start"});
        drive(0);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_cycle(k);
            drive(k + 1);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        pol = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 reset");
        rd(18, r); chk("R1 status", r, 32'd0);

        // Configuration A: active windows, counters on, early fetch
        tg = "cfgA";
        hp = 10; hsw = 2; hbp = 2; hfp = 2;
        vsw = 1; vbp = 1; nl = 6; vfp = 1; skew = 0;
        use_ha = 1; use_va = 1; ahs = 5; ahe = 6; avs = 30; ave = 39;
        fetch_on = 1; fetch_at = 5; cnt_on = 1; pol = 3'b000;
        mark_b = 24; mark_abs = 95; sticky_exp = 0;
        program_cfg();
        rd(2, r); chk("R12 line ctl readback", r, 32'((hp << 16) | hsw));
        rd(1, r); chk("R12 config readback", r, 32'h6000_0000 | 32'h8000_0000);
        run(130);

        // Stop: counters clear and outputs go idle
        wr(0, 32'h0);
        @(negedge clk);
        check_idle("R11 stopped");
        rd(0, r); chk("R12 enable readback", r, 32'd0);
        wr(18, 32'h1);
        sticky_exp = 0;
        rd(18, r); chk("R7 status cleared", r, 32'd0);

        // Configuration B: skew, inverted polarity, counters off, late fetch
        tg = "cfgB R8";
        hp = 12; hsw = 3; hbp = 1; hfp = 2;
        vsw = 2; vbp = 1; nl = 6; vfp = 1; skew = 3;
        use_ha = 0; use_va = 0; ahs = 0; ahe = 0; avs = 0; ave = 0;
        fetch_on = 1; fetch_at = 70; cnt_on = 0; pol = 3'b111;
        mark_b = 50; mark_abs = -1;
        program_cfg();
        @(negedge clk);
        check_idle("R8 inverted");
        run(150);

        done = 1;
        summary();
        $finish;
    end
endmodule